// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block is a synchronous supervisor that sits between a host bus and a byte-wide memory array. It watches three digitised supply-level flags from external comparators: supply above the operating level (about 4.5 V), supply below the protect trip level (about 4.25 V), and supply below the backup switchover level (about 3.0 V). From these flags it decides whether the host may reach the array, whether writes are blocked and the data drivers are floated, and whether the array runs from the backup cell.

The supervisor has four states: battery retention, protected, power-up recovery and normal running. Each flag first passes through a two-stage synchroniser and then a persistence filter. A level is accepted only after it has held for a set number of clocks. After the supply comes back, the supervisor keeps the array deselected for a programmable hold-off. It enters normal running only when that hold-off has finished and the host has released chip enable. A host write that is in progress when protection trips is cut off at once and reported to the host with a one-cycle abort pulse.

Top module: `pwr_guard`

## Requirements
- R1: While reset is held and right after it, the block is in battery retention: bat_sel_o=1, ready_o=0, wr_inhibit_o=1, out_hiz_o=1, wr_abort_o=0, mem_sel_o=0, mem_wr_o=0.
- R2: Each supply flag passes two synchroniser flops and is accepted only after it has held its new level for FLT_CYC consecutive clocks. A change applied before clock edge 1 reaches the state outputs after edge FLT_CYC+3. A pulse that lasts FLT_CYC-1 clocks has no effect.
- R3: ready_o=1 only in normal running. Normal running is reached only while the accepted flags show the supply above the operating level and not below the trip level. While ready_o=1, wr_inhibit_o=0 and out_hiz_o=0.
- R4: In normal running, an accepted trip flag or the loss of the operating flag moves the block to protected on the next edge: ready_o=0, wr_inhibit_o=1, out_hiz_o=1.
- R5: While ready_o=0, the host chip-enable and write-enable inputs are ignored: mem_sel_o=0 and mem_wr_o=0.
- R6: An accepted backup flag drives bat_sel_o=1 on the next edge from any state. When the flag clears, bat_sel_o falls on the next edge and the block goes to protected.
- R7: Recovery starts when the flags are good again and lasts HOLD_CYC clocks before normal running can begin. A trip or the loss of the operating flag during recovery returns the block to protected and restarts the count from zero.
- R8: At the end of the hold-off, normal running begins only on the edge after host_ce_i is seen low. While host_ce_i stays high, the block stays in recovery.
- R9: If host_ce_i=1 and host_we_i=1 on the edge that leaves normal running, wr_abort_o=1 for exactly that one following cycle.
- R10: While ready_o=1, mem_sel_o follows host_ce_i and mem_wr_o equals host_ce_i AND host_we_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sup_ok_i | input | 1 | Supply above operating level (async) |
| sup_trip_i | input | 1 | Supply below protect trip level (async) |
| sup_bat_i | input | 1 | Supply below backup switchover level (async) |
| host_ce_i | input | 1 | Host chip enable, active high |
| host_we_i | input | 1 | Host write enable, active high |
| wr_inhibit_o | output | 1 | Writes to the array blocked |
| out_hiz_o | output | 1 | Array data drivers held in high impedance |
| bat_sel_o | output | 1 | Array powered from backup cell |
| ready_o | output | 1 | Normal running, host access allowed |
| wr_abort_o | output | 1 | One-cycle pulse: a host write was cut off |
| mem_sel_o | output | 1 | Gated chip select to the array |
| mem_wr_o | output | 1 | Gated write strobe to the array |

## Verification
The assertions check on every cycle that the following hold. An accepted backup flag selects the cell on the next edge. An accepted trip ends normal running on the next edge. Every entry into normal running follows good flags, a finished hold-off and a released chip enable. An abort pulse always follows a live write. A filtered flag only changes toward its synchronised input. Some behaviour only the bench scenarios can show: the exact latency from a raw flag to the outputs, the rejection of a pulse one clock too short, the full hold-off length and its restart after a dip, and the gating of host strobes through a whole power-down and power-up sequence.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

    typedef enum logic [1:0] {
        PG_BATT  = 2'd0,
        PG_PROT  = 2'd1,
        PG_RECOV = 2'd2,
        PG_RUN   = 2'd3
    } pg_state_e;

    typedef struct packed {
        pg_state_e state;
        logic      abort;
    } pg_fsm_t;

    localparam int FLAG_OK   = 0;
    localparam int FLAG_TRIP = 1;
    localparam int FLAG_BAT  = 2;
    localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/pg_flag_lane.sv
module pg_flag_lane #(
    parameter int   FLT_CYC = 4,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CW = (FLT_CYC < 2) ? 1 : $clog2(FLT_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(FLT_CYC - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          flt;
        logic [CW-1:0] cnt;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d    = lane_q;
        lane_d.s1 = raw_i;
        lane_d.s2 = lane_q.s1;
        if (lane_q.s2 == lane_q.flt) begin
            lane_d.cnt = '0;
        end else if (lane_q.cnt == LIM) begin
            lane_d.flt = lane_q.s2;
            lane_d.cnt = '0;
        end else begin
            lane_d.cnt = lane_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lane_q <= '{s1: RST_VAL, s2: RST_VAL, flt: RST_VAL, cnt: '0};
        end else begin
            lane_q <= lane_d;
        end
    end

    assign flt_o = lane_q.flt;

    AST_FLT_TOWARD_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(flt_o) |-> ($past(lane_q.s2) == flt_o)); // R2

endmodule

// File: rtl/pg_flag_bank.sv
module pg_flag_bank #(
    parameter int                NFLAG   = 3,
    parameter int                FLT_CYC = 4,
    parameter logic [NFLAG-1:0]  RST_VEC = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NFLAG-1:0] raw_i,
    output logic [NFLAG-1:0] flt_o
);
    for (genvar g = 0; g < NFLAG; g++) begin : g_lane
        pg_flag_lane #(
            .FLT_CYC (FLT_CYC),
            .RST_VAL (RST_VEC[g])
        ) lane_i (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .raw_i (raw_i[g]),
            .flt_o (flt_o[g])
        );
    end

endmodule

// File: rtl/pg_holdoff.sv
module pg_holdoff #(
    parameter int HOLD_CYC = 500000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic done_o
);
    localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] LIM = HW'(HOLD_CYC - 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != LIM) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done_o = run_i && (tmr_q.cnt == LIM);

    AST_HOLD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (tmr_q.cnt == '0)); // R7

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard #(
    parameter int FLT_CYC  = 4,
    parameter int HOLD_CYC = 500000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sup_ok_i,
    input  logic sup_trip_i,
    input  logic sup_bat_i,
    input  logic host_ce_i,
    input  logic host_we_i,
    output logic wr_inhibit_o,
    output logic out_hiz_o,
    output logic bat_sel_o,
    output logic ready_o,
    output logic wr_abort_o,
    output logic mem_sel_o,
    output logic mem_wr_o
);
    import pwr_guard_pkg::*;

    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] flt_flags;
    logic ok_f, trip_f, bat_f;
    logic hold_done;
    logic supply_good;
    logic wr_live;

    pg_fsm_t fsm_d, fsm_q;

    assign raw_flags[FLAG_OK]   = sup_ok_i;
    assign raw_flags[FLAG_TRIP] = sup_trip_i;
    assign raw_flags[FLAG_BAT]  = sup_bat_i;

    // safe reset view: supply lost, backup in use
    pg_flag_bank #(
        .NFLAG  (NUM_FLAGS),
        .FLT_CYC(FLT_CYC),
        .RST_VEC(3'b110)
    ) flags_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .raw_i (raw_flags),
        .flt_o (flt_flags)
    );

    assign ok_f   = flt_flags[FLAG_OK];
    assign trip_f = flt_flags[FLAG_TRIP];
    assign bat_f  = flt_flags[FLAG_BAT];
    assign supply_good = ok_f && !trip_f;
    assign wr_live = host_ce_i && host_we_i;

    pg_holdoff #(
        .HOLD_CYC(HOLD_CYC)
    ) hold_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (fsm_q.state == PG_RECOV),
        .done_o(hold_done)
    );

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.abort = 1'b0;
        unique case (fsm_q.state)
            PG_BATT: begin
                if (!bat_f) fsm_d.state = PG_PROT;
            end
            PG_PROT: begin
                if (bat_f)            fsm_d.state = PG_BATT;
                else if (supply_good) fsm_d.state = PG_RECOV;
            end
            PG_RECOV: begin
                if (bat_f)                        fsm_d.state = PG_BATT;
                else if (!supply_good)            fsm_d.state = PG_PROT;
                else if (hold_done && !host_ce_i) fsm_d.state = PG_RUN;
            end
            PG_RUN: begin
                if (bat_f) begin
                    fsm_d.state = PG_BATT;
                    fsm_d.abort = wr_live;
                end else if (!supply_good) begin
                    fsm_d.state = PG_PROT;
                    fsm_d.abort = wr_live;
                end
            end
            default: fsm_d.state = PG_BATT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{state: PG_BATT, abort: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ready_o      = (fsm_q.state == PG_RUN);
    assign wr_inhibit_o = !ready_o;
    assign out_hiz_o    = !ready_o;
    assign bat_sel_o    = (fsm_q.state == PG_BATT);
    assign wr_abort_o   = fsm_q.abort;
    assign mem_sel_o    = ready_o && host_ce_i;
    assign mem_wr_o     = ready_o && wr_live;

    AST_BAT_FOLLOWS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bat_f |=> bat_sel_o); // R6

    AST_TRIP_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && trip_f) |=> !ready_o); // R4

    AST_RUN_NEEDS_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> $past(ok_f && !trip_f && !bat_f)); // R3

    AST_RUN_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> $past(hold_done)); // R7

    AST_RUN_CE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> $past(!host_ce_i)); // R8

    AST_ABORT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_abort_o |-> $past(ready_o && host_ce_i && host_we_i)); // R9

    AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_abort_o |=> !wr_abort_o); // R9

endmodule

// File: tb/pwr_guard_tb_top.sv
module pwr_guard_tb_top;

    localparam int S = 3;
    localparam int H = 20;

    // observed vector order: {ready, inhibit, hiz, bat, abort, msel, mwr}
    localparam logic [6:0] M_RDY = 7'b1000000;
    localparam logic [6:0] M_WI  = 7'b0100000;
    localparam logic [6:0] M_HZ  = 7'b0010000;
    localparam logic [6:0] M_BAT = 7'b0001000;
    localparam logic [6:0] M_ABT = 7'b0000100;
    localparam logic [6:0] M_SEL = 7'b0000010;
    localparam logic [6:0] M_WR  = 7'b0000001;
    localparam logic [6:0] M_ALL = 7'b1111111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vok = 1'b0, vtrip = 1'b1, vbat = 1'b1, ce = 1'b0, we = 1'b0;
    logic wi, hz, bs, rdy, abt, msel, mwr;

    always #2 clk = ~clk;

    pwr_guard #(.FLT_CYC(S), .HOLD_CYC(H)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .sup_ok_i(vok), .sup_trip_i(vtrip), .sup_bat_i(vbat),
        .host_ce_i(ce), .host_we_i(we),
        .wr_inhibit_o(wi), .out_hiz_o(hz), .bat_sel_o(bs), .ready_o(rdy),
        .wr_abort_o(abt), .mem_sel_o(msel), .mem_wr_o(mwr)
    );

    typedef struct {
        int         cyc;
        logic [6:0] exp;
        logic [6:0] msk;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int cyc_cnt = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    task automatic push_at(input int at, input logic [6:0] e, input logic [6:0] m, input string tag);
        sb_item_t it;
        int pos;
        it.cyc = at; it.exp = e; it.msk = m; it.tag = tag;
        pos = sb_q.size();
        for (int i = 0; i < sb_q.size(); i++) begin
            if (sb_q[i].cyc > at) begin pos = i; break; end
        end
        sb_q.insert(pos, it);
    endtask

    task automatic push_exp(input int dly, input logic [6:0] e, input logic [6:0] m, input string tag);
        push_at(cyc_cnt + dly, e, m, tag);
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expectations due this cycle, samples after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0 && sb_q[0].cyc <= cyc_cnt) begin
                sb_item_t it;
                logic [6:0] act;
                it = sb_q.pop_front();
                act = {rdy, wi, hz, bs, abt, msel, mwr};
                n_cmp++;
                if (it.cyc != cyc_cnt || ((act ^ it.exp) & it.msk) != 7'b0) begin
                    n_bad++;
                    $display("FAIL %s cyc %0d: actual %b expected %b mask %b",
                             it.tag, cyc_cnt, act, it.exp, it.msk);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int c0, d0, e0, c1;
        wait_neg(3);
        rst_n = 1'b1;
        // R1 reset state
        push_exp(1, 7'b0111000, M_ALL, "R1 reset state");

        // power-up from battery retention: R6 release, R7 hold-off, R3 run
        @(negedge clk);
        vok = 1'b1; vtrip = 1'b0; vbat = 1'b0;
        push_exp(S + 2, 7'b0001000, M_BAT, "R2 latency bat still set");
        push_exp(S + 3, 7'b0100000, M_BAT | M_WI | M_RDY, "R6 bat released to protect");
        push_exp(S + 3 + H, 7'b0000000, M_RDY, "R7 hold-off not yet over");
        push_exp(S + 4 + H, 7'b1000000, M_RDY | M_WI | M_HZ | M_BAT, "R3 running");
        wait_neg(S + 6 + H);

        // R10 host pass-through while ready
        ce = 1'b1; we = 1'b1;
        push_exp(1, 7'b0000011, M_SEL | M_WR, "R10 write passes");
        @(negedge clk);
        we = 1'b0;
        push_exp(1, 7'b0000010, M_SEL | M_WR, "R10 read select");
        @(negedge clk);
        ce = 1'b0;

        // R2 short pulse rejected
        @(negedge clk);
        vtrip = 1'b1;
        wait_neg(S - 1);
        vtrip = 1'b0;
        push_exp(S + 2, 7'b1000000, M_RDY, "R2 short trip ignored a");
        push_exp(2 * S + 6, 7'b1000000, M_RDY | M_WI, "R2 short trip ignored b");
        wait_neg(2 * S + 8);

        // R4 trip during write, R9 abort
        ce = 1'b1; we = 1'b1; vtrip = 1'b1;
        push_exp(S + 2, 7'b1000001, M_RDY | M_WR, "R2 trip latency");
        push_exp(S + 3, 7'b0110100, M_RDY | M_WI | M_HZ | M_ABT | M_WR, "R4 R9 protect with abort");
        push_exp(S + 4, 7'b0000000, M_ABT, "R9 single pulse");
        wait_neg(S + 5);
        // R5 host ignored while protected
        push_exp(1, 7'b0000000, M_SEL | M_WR, "R5 strobes blocked");
        @(negedge clk);
        we = 1'b0;
        push_exp(1, 7'b0000000, M_SEL | M_WR, "R5 select blocked");
        @(negedge clk);
        ce = 1'b0;

        // R7 restart of hold-off on a dip during recovery
        @(negedge clk);
        c0 = cyc_cnt;
        vtrip = 1'b0;
        wait_neg(S + 8);
        d0 = cyc_cnt;
        vtrip = 1'b1;
        push_at(c0 + S + 3 + H, 7'b0000000, M_RDY, "R7 restart no early run");
        wait_neg(2 * S);
        e0 = cyc_cnt;
        vtrip = 1'b0;
        push_at(e0 + S + 2 + H, 7'b0000000, M_RDY, "R7 restarted count pending");
        push_at(e0 + S + 3 + H, 7'b1000000, M_RDY, "R7 restarted count done");
        wait_neg(S + 5 + H);
        if (d0 < c0) n_bad++;

        // R8 chip enable held through end of hold-off
        vtrip = 1'b1;
        wait_neg(S + 4);
        c1 = cyc_cnt;
        ce = 1'b1; vtrip = 1'b0;
        push_at(c1 + S + 3 + H, 7'b0000000, M_RDY | M_SEL, "R8 waits for ce low a");
        push_at(c1 + S + 6 + H, 7'b0000000, M_RDY | M_SEL, "R8 waits for ce low b");
        wait_neg(S + 7 + H);
        ce = 1'b0;
        push_exp(1, 7'b1000000, M_RDY | M_WI, "R8 run after ce low");
        wait_neg(3);

        // R6 supply collapse straight to battery, then partial return
        vok = 1'b0; vtrip = 1'b1; vbat = 1'b1;
        push_exp(S + 2, 7'b1000000, M_RDY | M_BAT, "R6 before accept");
        push_exp(S + 3, 7'b0111000, M_RDY | M_WI | M_HZ | M_BAT | M_ABT, "R6 battery selected");
        wait_neg(S + 6);
        vbat = 1'b0;
        push_exp(S + 3, 7'b0100000, M_BAT | M_RDY | M_WI, "R6 battery released");
        push_exp(S + 5 + H, 7'b0000000, M_RDY | M_BAT, "R3 no run without ok");
        wait_neg(S + 7 + H);

        wait (sb_q.size() == 0);
        wait_neg(2);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule